// File: doc/BRIEF.md
# Qualified Chip-Select Decoder with ROM Wait-States

This block sits between a CPU with a 24-bit address bus and the memory and peripheral devices. It sorts each address into a region (RAM, ROM, one of several I/O devices, or unmapped) and drives the matching active-low chip select. Two status outputs of the CPU say whether the address is valid. One marks a valid program address and the other a valid data address. When both are low the cycle is dead: the address may be garbage and nothing should respond to it.

A build-time parameter sets where the qualification is applied. In upstream mode, the OR of the two status bits enables the whole decoder, so a dead cycle reaches neither memory nor I/O. In downstream mode, the decoder runs on the raw address and only the I/O selects are gated, by the data-valid bit alone. This mode needs no OR gate in the select path and keeps that path shallower.

ROM reads are stretched by a ready line that holds the CPU for a set number of clocks. The block also drives an active-high enable that follows the data-valid bit. Peripherals with both an active-high and an active-low select input can use it.

Top module: `cs_qualified_decoder`

## Requirements
- R1: While `rst_n` is low, every active-low select is high, `io_en` is low and `rdy` is high.
- R2: With default parameters, the address decodes as follows. Bank 0 offsets 0x0000–0xBFFF and every address in a nonzero bank are RAM. Bank 0 offsets 0xE000–0xFFFF are ROM. Bank 0 offsets 0xC000–0xC0FF are I/O, and device index = address bits [7:5] drives `io_cs_n[index]`. Bank 0 offsets 0xC100–0xDFFF assert no select.
- R3: With `QUAL_UPSTREAM`=1, no select is asserted when `vpa` and `vda` are both 0. When either one is 1, every region, I/O included, decodes as in R2.
- R4: With `QUAL_UPSTREAM`=0, the RAM and ROM selects follow the address whatever `vpa` and `vda` are. An I/O select is asserted only when `vda` is 1, and `vpa` has no effect on it.
- R5: `rom_cs_n` goes low only on read cycles (`rwb`=1). A write to the ROM range asserts no select.
- R6: Outside reset, `io_en` equals `vda`.
- R7: The first cycle of a ROM read with `vpa` or `vda` high drives `rdy` low. While the same access is held, `rdy` stays low for `WAIT_CYCLES` cycles in all, then goes high for one cycle. A ROM read still present after that cycle starts a new stretch.
- R8: A dead cycle, a write, or any non-ROM cycle keeps `rdy` high and clears any partial stretch. This holds in both modes, even when the address is in the ROM range.
- R9: At most one of `ram_cs_n`, `rom_cs_n` and the `io_cs_n` bits is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (24) | CPU address, bank in the upper bits |
| vpa | input | 1 | CPU status: valid program address |
| vda | input | 1 | CPU status: valid data address |
| rwb | input | 1 | 1 = read, 0 = write |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| io_cs_n | output | IO_DEV_CNT (8) | One active-low select per I/O device |
| io_en | output | 1 | Active-high I/O enable carrying `vda` |
| rdy | output | 1 | Ready to CPU; low holds the cycle |

## Verification
All selects and `io_en` are combinational, so each one is due in the same cycle as the address and status bits that cause it. `rdy` is also combinational, but it depends on the stretch counter. That counter only moves at rising edges, so the expected `rdy` for a cycle follows from the cycles already driven. The bench drives inputs on the falling edge and records the expectation in that same cycle. It compares a quarter period later, before the next rising edge, so the value seen is the one for that cycle's inputs. Two instances run side by side, one per qualification mode and with different wait counts. Each instance gets its own reference counter.

// File: rtl/cs_map_pkg.sv
// Package: shared region encoding and width helper for the chip-select decoder.
// Assumes: nothing beyond SystemVerilog-2017.
package cs_map_pkg;

    // Region a bus address falls into after decoding.
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_ROM  = 2'd2,
        RGN_IO   = 2'd3
    } region_e;

    // Bits needed to index n items, never less than one.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cs_region_decode.sv
// Module: cs_region_decode
// Sorts an address into RAM, ROM, I/O or unmapped, and yields the I/O device
// index. With enable low the result is RGN_NONE.
// Assumes: the I/O window and ROM window both lie inside bank 0. ROM runs from
// ROM_BASE to the top of the bank. Overlaps resolve as I/O, then ROM, then RAM.
module cs_region_decode
    import cs_map_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int OFFS_W       = 16,
    parameter int RAM_TOP      = 'hBFFF,
    parameter int IO_BASE      = 'hC000,
    parameter int IO_DEV_CNT   = 8,
    parameter int IO_DEV_BYTES = 32,
    parameter int ROM_BASE     = 'hE000,
    localparam int IO_IDX_W    = idx_width(IO_DEV_CNT)
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                enable,
    output region_e             region,
    output logic [IO_IDX_W-1:0] io_idx
);

    localparam int IO_OFS_W = idx_width(IO_DEV_BYTES);
    localparam logic [OFFS_W-1:0] RAM_TOP_O = OFFS_W'(RAM_TOP);
    localparam logic [OFFS_W-1:0] IO_BASE_O = OFFS_W'(IO_BASE);
    localparam logic [OFFS_W:0]   IO_END_O  = (OFFS_W+1)'(IO_BASE + IO_DEV_CNT * IO_DEV_BYTES);
    localparam logic [OFFS_W-1:0] ROM_BASE_O = OFFS_W'(ROM_BASE);

    logic              bank_zero;
    logic [OFFS_W-1:0] offs;
    logic              io_hit;
    logic              rom_hit;
    logic              ram_hit;

    // Split the address into bank and in-bank offset.
    always_comb begin
        bank_zero = (addr[ADDR_W-1:OFFS_W] == '0);
        offs      = addr[OFFS_W-1:0];
    end

    // Window compares for each region.
    always_comb begin
        io_hit  = bank_zero && (offs >= IO_BASE_O) && ({1'b0, offs} < IO_END_O);
        rom_hit = bank_zero && (offs >= ROM_BASE_O);
        ram_hit = !bank_zero || (offs <= RAM_TOP_O);
    end

    // Device number inside the I/O window.
    always_comb begin
        io_idx = IO_IDX_W'((offs - IO_BASE_O) >> IO_OFS_W);
    end

    // Priority pick of the region, blocked when not enabled.
    always_comb begin
        region = RGN_NONE;
        if (enable) begin
            if (io_hit)       region = RGN_IO;
            else if (rom_hit) region = RGN_ROM;
            else if (ram_hit) region = RGN_RAM;
        end
    end

endmodule

// File: rtl/cs_io_select.sv
// Module: cs_io_select
// Expands an I/O hit and a device index into one active-low select per
// device, all of them gated by a single qualifier.
// Assumes: idx is only meaningful while hit is high.
module cs_io_select #(
    parameter int IO_DEV_CNT = 8,
    parameter int IO_IDX_W   = 3
) (
    input  logic                  hit,
    input  logic                  gate,
    input  logic [IO_IDX_W-1:0]   idx,
    output logic [IO_DEV_CNT-1:0] io_cs_n
);

    // One comparator per device.
    for (genvar g = 0; g < IO_DEV_CNT; g++) begin : g_dev
        assign io_cs_n[g] = !(hit && gate && (idx == IO_IDX_W'(g)));
    end

endmodule

// File: rtl/cs_rom_wait.sv
// Module: cs_rom_wait
// Stretches a qualified ROM read. Ready drops in the first cycle of the
// request and stays low for WAIT_CYCLES cycles in all. It then goes high for
// one cycle, which completes the access. Any cycle without a request clears
// the count.
// Assumes: rom_req is already qualified by reset and the address-valid bits.
module cs_rom_wait #(
    parameter int WAIT_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rom_req,
    output logic rdy
);

    localparam int               CNT_W = cs_map_pkg::idx_width(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_CYCLES);

    logic [CNT_W-1:0] cnt;
    logic             stretch;

    // Hold the CPU while the request is present and the count is short.
    always_comb begin
        stretch = rom_req && (cnt < LIMIT);
        rdy     = !stretch;
    end

    // Count cycles of the current stretch; clear on any break.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (stretch) cnt <= cnt + 1'b1;
        else              cnt <= '0;
    end

    // R7: the count never passes the programmed wait.
    assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

    // R8: a cycle without a request leaves the counter cleared.
    assert_idle_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rom_req) |-> (cnt == '0));

endmodule

// File: rtl/cs_qualified_decoder.sv
// Module: cs_qualified_decoder (top)
// Drives chip selects for RAM, ROM and I/O devices from a 24-bit CPU
// address, qualified by the valid-program and valid-data status bits, and
// stretches ROM reads through rdy. QUAL_UPSTREAM picks where qualification
// is applied: 1 gates the whole decoder with vpa|vda, 0 gates only the I/O
// selects with vda.
// Assumes: the CPU holds address and status stable while rdy is low.
module cs_qualified_decoder
    import cs_map_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int OFFS_W        = 16,
    parameter int RAM_TOP       = 'hBFFF,
    parameter int IO_BASE       = 'hC000,
    parameter int IO_DEV_CNT    = 8,
    parameter int IO_DEV_BYTES  = 32,
    parameter int ROM_BASE      = 'hE000,
    parameter int WAIT_CYCLES   = 1,
    parameter bit QUAL_UPSTREAM = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  vpa,
    input  logic                  vda,
    input  logic                  rwb,
    output logic                  ram_cs_n,
    output logic                  rom_cs_n,
    output logic [IO_DEV_CNT-1:0] io_cs_n,
    output logic                  io_en,
    output logic                  rdy
);

    localparam int IO_IDX_W = idx_width(IO_DEV_CNT);

    logic                dec_en;
    logic                io_gate;
    logic                addr_valid;
    logic                rom_req;
    region_e             region;
    logic [IO_IDX_W-1:0] io_idx;

    // Either status bit marks a live bus cycle.
    assign addr_valid = vpa | vda;

    // Place the qualifier at the chosen point of the select path.
    if (QUAL_UPSTREAM) begin : g_upstream
        assign dec_en  = rst_n & addr_valid;
        assign io_gate = 1'b1;
    end else begin : g_downstream
        assign dec_en  = rst_n;
        assign io_gate = vda;
    end

    cs_region_decode #(
        .ADDR_W       (ADDR_W),
        .OFFS_W       (OFFS_W),
        .RAM_TOP      (RAM_TOP),
        .IO_BASE      (IO_BASE),
        .IO_DEV_CNT   (IO_DEV_CNT),
        .IO_DEV_BYTES (IO_DEV_BYTES),
        .ROM_BASE     (ROM_BASE)
    ) u_decode (
        .addr   (addr),
        .enable (dec_en),
        .region (region),
        .io_idx (io_idx)
    );

    // Memory selects; ROM answers reads only.
    always_comb begin
        ram_cs_n = !(region == RGN_RAM);
        rom_cs_n = !((region == RGN_ROM) && rwb);
    end

    cs_io_select #(
        .IO_DEV_CNT (IO_DEV_CNT),
        .IO_IDX_W   (IO_IDX_W)
    ) u_io_sel (
        .hit     (region == RGN_IO),
        .gate    (io_gate),
        .idx     (io_idx),
        .io_cs_n (io_cs_n)
    );

    // Active-high companion enable for dual-select peripherals.
    assign io_en = rst_n & vda;

    // Wait-states start only on a live ROM read, in either mode.
    assign rom_req = (region == RGN_ROM) && rwb && addr_valid;

    cs_rom_wait #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .rom_req (rom_req),
        .rdy     (rdy)
    );

    // R1: reset parks every output.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> (ram_cs_n && rom_cs_n && (&io_cs_n) && !io_en && rdy));

    // R9: the selects never overlap.
    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ram_cs_n, ~rom_cs_n, ~io_cs_n}));

    // R5: a write never selects ROM.
    assert_rom_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rwb |-> rom_cs_n);

    // R8: a dead cycle never holds the CPU.
    assert_dead_no_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpa && !vda) |-> rdy);

    // R7: a stretch only happens under an asserted ROM select.
    assert_wait_under_rom_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> !rom_cs_n);

    if (QUAL_UPSTREAM) begin : g_chk_up
        // R3: a dead cycle selects nothing.
        assert_dead_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!vpa && !vda) |-> (ram_cs_n && rom_cs_n && (&io_cs_n)));
    end else begin : g_chk_dn
        // R4: I/O needs the data-valid bit.
        assert_io_needs_vda_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !vda |-> (&io_cs_n));
    end

endmodule

// File: tb/test_cs_qualified_decoder.sv
// Scoreboard bench: a driver task applies one bus cycle to both modes and
// queues the expected outputs; a monitor pops and compares before the edge.
module test_cs_qualified_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NDEV       = 8;
    localparam int WAIT_UP    = 1;
    localparam int WAIT_DN    = 2;

    typedef struct {
        logic            ram_n;
        logic            rom_n;
        logic [NDEV-1:0] io_n;
        logic            io_en;
        logic            rdy;
        string           tag_sel;
        string           tag_rdy;
    } exp_t;

    typedef struct {
        exp_t up;
        exp_t dn;
    } item_t;

    logic        clk;
    logic        rst_n;
    logic [23:0] addr;
    logic        vpa, vda, rwb;

    logic            up_ram_n, up_rom_n, up_io_en, up_rdy;
    logic [NDEV-1:0] up_io_n;
    logic            dn_ram_n, dn_rom_n, dn_io_en, dn_rdy;
    logic [NDEV-1:0] dn_io_n;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    int    cnt_up = 0;
    int    cnt_dn = 0;
    bit    done   = 0;

    cs_qualified_decoder #(.WAIT_CYCLES(WAIT_UP), .QUAL_UPSTREAM(1'b1)) i_cs_qualified_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .vpa(vpa), .vda(vda), .rwb(rwb),
        .ram_cs_n(up_ram_n), .rom_cs_n(up_rom_n), .io_cs_n(up_io_n),
        .io_en(up_io_en), .rdy(up_rdy));

    cs_qualified_decoder #(.WAIT_CYCLES(WAIT_DN), .QUAL_UPSTREAM(1'b0)) i_cs_qualified_decoder_dn (
        .clk(clk), .rst_n(rst_n), .addr(addr), .vpa(vpa), .vda(vda), .rwb(rwb),
        .ram_cs_n(dn_ram_n), .rom_cs_n(dn_rom_n), .io_cs_n(dn_io_n),
        .io_en(dn_io_en), .rdy(dn_rdy));

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model of one cycle (R1..R8); returns the next stretch count.
    function automatic exp_t model(input bit up, input logic [23:0] a, input logic p,
                                   input logic d, input logic w, input logic r,
                                   input int cnt, input int waitc, output int nxt);
        exp_t e;
        int   rg;
        int   idx;
        bit   qual;
        bit   req;
        rg  = 0;
        idx = 0;
        if (a[23:16] != 8'h00)   rg = 1;
        else if (a[15:0] <= 16'hBFFF) rg = 1;
        else if (a[15:0] <= 16'hC0FF) begin rg = 3; idx = int'(a[7:5]); end
        else if (a[15:0] >= 16'hE000) rg = 2;
        qual    = up ? (p | d) : 1'b1;
        e.ram_n = 1'b1;
        e.rom_n = 1'b1;
        e.io_n  = '1;
        if (r && qual) begin
            if (rg == 1) e.ram_n = 1'b0;
            if (rg == 2) e.rom_n = !w;
            if (rg == 3 && (up || d)) e.io_n[idx] = 1'b0;
        end
        e.io_en = r & d;
        req     = r && (rg == 2) && w && (p | d);
        e.rdy   = !(req && cnt < waitc);
        nxt     = (req && cnt < waitc) ? cnt + 1 : 0;
        if (!r)                 e.tag_sel = "R1";
        else if (rg == 2 && !w) e.tag_sel = "R5";
        else if (up)            e.tag_sel = (!p && !d) ? "R3" : "R2";
        else                    e.tag_sel = "R4";
        if (!r)       e.tag_rdy = "R1";
        else if (req) e.tag_rdy = "R7";
        else          e.tag_rdy = "R8";
        return e;
    endfunction

    // Driver: apply one cycle at the falling edge and queue its expectation.
    task automatic step(input logic [23:0] a, input logic p, input logic d,
                        input logic w, input logic r);
        item_t it;
        int    nu, nd;
        @(negedge clk);
        addr = a; vpa = p; vda = d; rwb = w; rst_n = r;
        it.up = model(1'b1, a, p, d, w, r, cnt_up, WAIT_UP, nu);
        it.dn = model(1'b0, a, p, d, w, r, cnt_dn, WAIT_DN, nd);
        q.push_back(it);
        cnt_up = nu;
        cnt_dn = nd;
    endtask

    task automatic chk(input string tag, input string what, input logic [NDEV-1:0] act,
                       input logic [NDEV-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s addr=%h vpa=%b vda=%b rwb=%b actual=%b expected=%b",
                     tag, what, addr, vpa, vda, rwb, act, exp);
        end
    endtask

    task automatic compare(input string inst, input exp_t e, input logic ram_n,
                           input logic rom_n, input logic [NDEV-1:0] io_n,
                           input logic io_en, input logic rdy);
        int low;
        chk(e.tag_sel, {inst, " ram_cs_n"}, NDEV'(ram_n), NDEV'(e.ram_n));
        chk(e.tag_sel, {inst, " rom_cs_n"}, NDEV'(rom_n), NDEV'(e.rom_n));
        chk(e.tag_sel, {inst, " io_cs_n"}, io_n, e.io_n);
        chk(rst_n ? "R6" : "R1", {inst, " io_en"}, NDEV'(io_en), NDEV'(e.io_en));
        chk(e.tag_rdy, {inst, " rdy"}, NDEV'(rdy), NDEV'(e.rdy));
        low = (ram_n === 1'b0) + (rom_n === 1'b0) + $countones(~io_n);
        chk("R9", {inst, " select overlap"}, NDEV'(low > 1), NDEV'(0));
    endtask

    // Monitor: compare a quarter period after the drive, before the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                compare("upstream", it.up, up_ram_n, up_rom_n, up_io_n, up_io_en, up_rdy);
                compare("downstream", it.dn, dn_ram_n, dn_rom_n, dn_io_n, dn_io_en, dn_rdy);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    logic [23:0] addrs [11] = '{24'h000010, 24'h00BFFF, 24'h00C000, 24'h00C020,
                                24'h00C0FF, 24'h00C100, 24'h00DFFF, 24'h00E000,
                                24'h00FFFF, 24'h010000, 24'hFFE000};

    initial begin
        rst_n = 1'b0; addr = '0; vpa = 1'b0; vda = 1'b0; rwb = 1'b1;
        // R1: reset with live ROM and I/O cycles presented.
        step(24'h00E000, 1'b1, 1'b1, 1'b1, 1'b0);
        step(24'h00C040, 1'b0, 1'b1, 1'b1, 1'b0);
        step(24'h001234, 1'b1, 1'b0, 1'b0, 1'b0);
        // R2..R9: sweep regions x status combinations x direction, held 4 cycles.
        for (int i = 0; i < 11; i++) begin
            for (int s = 0; s < 4; s++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int k = 0; k < 4; k++) begin
                        step(addrs[i], s[1], s[0], w[0], 1'b1);
                    end
                end
            end
        end
        // R2/R4: every I/O device under each status pattern.
        for (int dv = 0; dv < NDEV; dv++) begin
            for (int s = 0; s < 4; s++) begin
                step(24'h00C000 | 24'(dv * 32 + 5), s[1], s[0], 1'b1, 1'b1);
            end
        end
        // R7/R8: ROM fetch broken by dead cycles and writes mid-stretch.
        step(24'h00E100, 1'b1, 1'b0, 1'b1, 1'b1);
        step(24'h00E100, 1'b0, 1'b0, 1'b1, 1'b1);
        step(24'h00E100, 1'b1, 1'b0, 1'b1, 1'b1);
        step(24'h00E100, 1'b1, 1'b0, 1'b1, 1'b1);
        step(24'h00E100, 1'b0, 1'b1, 1'b0, 1'b1);
        step(24'h00E101, 1'b0, 1'b1, 1'b1, 1'b1);
        step(24'h00E101, 1'b0, 1'b1, 1'b1, 1'b1);
        step(24'h00E101, 1'b0, 1'b1, 1'b1, 1'b1);
        step(24'h000200, 1'b0, 1'b1, 1'b1, 1'b1);
        // R1: reset mid-stretch, then resume.
        step(24'h00FFF0, 1'b1, 1'b1, 1'b1, 1'b1);
        step(24'h00FFF0, 1'b1, 1'b1, 1'b1, 1'b0);
        step(24'h00FFF0, 1'b1, 1'b1, 1'b1, 1'b1);
        step(24'h00FFF0, 1'b1, 1'b1, 1'b1, 1'b1);
        step(24'h00FFF0, 1'b1, 1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        #(CLK_PERIOD/2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule